// File: doc/BRIEF.md
# Link Handshake Rule Monitor

This block watches one memory-mapped link made of five handshake channels: write address, write data, write response, read address and read data. It only observes. Every port except the error outputs is a copy of a link wire. On every channel it checks that a VALID, once raised, stays up until its READY is seen, and that the payload stays unchanged while the transfer is stalled. It also checks the ordering between channels: a write response may not appear before the final write beat has been accepted, and read data may not be accepted while no read request is open.

One burst per direction is tracked. A beat counter is loaded from the length field when the address handshake happens (the length field plus one gives the beat count). The counter is then compared with the last-beat flag on every data handshake. Write beats that come before their address are legal. They are counted as they arrive, and the count is checked against the length once the address arrives. Every violation sets its own sticky flag, and a single combined output shows that at least one flag is set. The monitor is plain synthesizable logic, so it can sit beside the link in silicon or in a simulation.

Top module: `hsLinkMonitor`

## Requirements
- R1: If a channel has VALID high and READY low in one cycle and VALID low in the next cycle, the drop flag for that channel is set. The drop flags sit at bits 0 (write address), 1 (write data), 2 (write response), 3 (read address) and 4 (read data) of `errFlags`.
- R2: If a channel stalls (VALID high, READY low) and its payload differs in the next cycle while VALID is still high, the hold flag for that channel is set. The hold flags sit at bits 5 to 9, in the same channel order as R1. The payloads are: {addr, len} for the address channels, {data, strobe, last} for write data, {resp} for the write response, and {data, resp, last} for read data.
- R3: The write strobe value while write VALID is low never sets any flag.
- R4: A read-data handshake while no read-address handshake is open sets bit 13. An address handshake in the same cycle as the data handshake does not count as open.
- R5: A write-response VALID seen while the current burst lacks either its address handshake or its accepted final data beat sets bit 12. This includes the cycle in which that final beat is accepted.
- R6: A write beat whose last flag disagrees with "this is beat length+1" sets bit 10. A read beat whose last flag disagrees sets bit 11. Either way, the burst is closed at that beat.
- R7: Write beats before their address handshake raise no flag. When the address arrives, the early beat count is compared with length+1. A finished early burst of the wrong size, or an unfinished one that already has length+1 or more beats, sets bit 10.
- R8: A second write-address handshake while a write burst is open, unless that burst's response handshake happens in the same cycle, sets bit 14. So does a write beat after the burst's final beat but before its response handshake. A read-address handshake while a read burst is open, unless that burst's final beat is accepted in the same cycle, sets bit 15.
- R9: Every flag stays set until reset. `errAny` is high exactly when some flag is set.
- R10: While reset is asserted and after it is released, all flags and `errAny` are low until a violation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awValid | input | 1 | Write address VALID |
| awReady | input | 1 | Write address READY |
| awAddr | input | ADDR_W | Write address |
| awLen | input | LEN_W | Write burst length minus one |
| wValid | input | 1 | Write data VALID |
| wReady | input | 1 | Write data READY |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Write byte strobes |
| wLast | input | 1 | Final write beat marker |
| bValid | input | 1 | Write response VALID |
| bReady | input | 1 | Write response READY |
| bResp | input | RESP_W | Write response code |
| arValid | input | 1 | Read address VALID |
| arReady | input | 1 | Read address READY |
| arAddr | input | ADDR_W | Read address |
| arLen | input | LEN_W | Read burst length minus one |
| rValid | input | 1 | Read data VALID |
| rReady | input | 1 | Read data READY |
| rData | input | DATA_W | Read data |
| rResp | input | RESP_W | Read response code |
| rLast | input | 1 | Final read beat marker |
| errFlags | output | 16 | Sticky violation flags, bit positions as in R1 to R8 |
| errAny | output | 1 | OR of all flags |

## Verification
The bench targets these corner cases, each with the fault a wrong design would show:
- A legal stall that keeps its payload, and a strobe that toggles while write VALID is low. A design that compares too eagerly would raise hold flags on clean traffic.
- Write data that fully precedes its address, and data that straddles the address handshake. A monitor that requires address first would flag legal traffic, and one that never reconciles would miss a wrongly sized early burst.
- An early last flag, a missing last flag, a response before the final beat, and read data with no request. Each must set exactly its own bit and no other.
- Overflow from a second request or an extra write beat. A monitor whose flags are not sticky would lose these after a few idle cycles.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  localparam int NUM_CH  = 5;
  localparam int CH_AW   = 0;
  localparam int CH_W    = 1;
  localparam int CH_B    = 2;
  localparam int CH_AR   = 3;
  localparam int CH_R    = 4;

  localparam int DROP_BASE = 0;
  localparam int HOLD_BASE = NUM_CH;
  localparam int ERR_WLAST = 2 * NUM_CH;
  localparam int ERR_RLAST = ERR_WLAST + 1;
  localparam int ERR_BORD  = ERR_WLAST + 2;
  localparam int ERR_RORD  = ERR_WLAST + 3;
  localparam int ERR_WOVF  = ERR_WLAST + 4;
  localparam int ERR_ROVF  = ERR_WLAST + 5;
  localparam int NUM_ERR   = ERR_ROVF + 1;

  // Strobes from the observing datapath to the burst control
  typedef struct packed {
    logic [NUM_CH-1:0] fire;
    logic [NUM_CH-1:0] drop;
    logic [NUM_CH-1:0] hold;
    logic              wLast;
    logic              rLast;
    logic              bValid;
  } evt_t;
endpackage

// File: rtl/hsStallWatch.sv
module hsStallWatch #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid,
  input  logic          ready,
  input  logic [PW-1:0] payload,
  output logic          fire,
  output logic          drop,
  output logic          hold
);
  logic          stallQ;
  logic [PW-1:0] payQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallQ <= 1'b0;
      payQ   <= '0;
    end else begin
      stallQ <= valid & ~ready;
      payQ   <= payload;
    end
  end

  // A stall last cycle obliges VALID and payload to persist this cycle
  always_comb begin
    fire = valid & ready;
    drop = stallQ & ~valid;
    hold = stallQ & valid & (payload != payQ);
  end
endmodule

// File: rtl/hsMonDatapath.sv
module hsMonDatapath
  import hsmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int RESP_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                awValid,
  input  logic                awReady,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic [LEN_W-1:0]    awLen,
  input  logic                wValid,
  input  logic                wReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wLast,
  input  logic                bValid,
  input  logic                bReady,
  input  logic [RESP_W-1:0]   bResp,
  input  logic                arValid,
  input  logic                arReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic [LEN_W-1:0]    arLen,
  input  logic                rValid,
  input  logic                rReady,
  input  logic [DATA_W-1:0]   rData,
  input  logic [RESP_W-1:0]   rResp,
  input  logic                rLast,
  output evt_t                evt
);
  localparam int AW_PW = ADDR_W + LEN_W;
  localparam int W_PW  = DATA_W + DATA_W/8 + 1;
  localparam int B_PW  = RESP_W;
  localparam int R_PW  = DATA_W + RESP_W + 1;

  logic [NUM_CH-1:0] fireV, dropV, holdV;

  hsStallWatch #(.PW(AW_PW)) uAw (
    .clk(clk), .rstN(rstN), .valid(awValid), .ready(awReady),
    .payload({awAddr, awLen}),
    .fire(fireV[CH_AW]), .drop(dropV[CH_AW]), .hold(holdV[CH_AW]));

  hsStallWatch #(.PW(W_PW)) uW (
    .clk(clk), .rstN(rstN), .valid(wValid), .ready(wReady),
    .payload({wData, wStrb, wLast}),
    .fire(fireV[CH_W]), .drop(dropV[CH_W]), .hold(holdV[CH_W]));

  hsStallWatch #(.PW(B_PW)) uB (
    .clk(clk), .rstN(rstN), .valid(bValid), .ready(bReady),
    .payload(bResp),
    .fire(fireV[CH_B]), .drop(dropV[CH_B]), .hold(holdV[CH_B]));

  hsStallWatch #(.PW(AW_PW)) uAr (
    .clk(clk), .rstN(rstN), .valid(arValid), .ready(arReady),
    .payload({arAddr, arLen}),
    .fire(fireV[CH_AR]), .drop(dropV[CH_AR]), .hold(holdV[CH_AR]));

  hsStallWatch #(.PW(R_PW)) uR (
    .clk(clk), .rstN(rstN), .valid(rValid), .ready(rReady),
    .payload({rData, rResp, rLast}),
    .fire(fireV[CH_R]), .drop(dropV[CH_R]), .hold(holdV[CH_R]));

  always_comb begin
    evt.fire   = fireV;
    evt.drop   = dropV;
    evt.hold   = holdV;
    evt.wLast  = wLast;
    evt.rLast  = rLast;
    evt.bValid = bValid;
  end
endmodule

// File: rtl/hsMonControl.sv
module hsMonControl
  import hsmon_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  evt_t               evt,
  input  logic [LEN_W-1:0]   awLen,
  input  logic [LEN_W-1:0]   arLen,
  output logic [NUM_ERR-1:0] errFlags
);
  localparam int CW = LEN_W + 1;

  logic          wAddrSeen, wDataDone, rAddrSeen;
  logic [CW-1:0] wCnt, wLen1, rCnt, rLen1;

  logic          wAddrNx, wDoneNx, rAddrNx;
  logic [CW-1:0] wCntNx, wLenNx, rCntNx, rLenNx;
  logic          wLastErr, rLastErr, bOrdErr, rOrdErr, wOvfErr, rOvfErr;
  logic          awFire, wFire, bFire, arFire, rFire;
  logic [CW-1:0] awLen1, arLen1, lenNow, wNew, rNew;
  logic          addrNow, rDoneNow;
  logic [NUM_ERR-1:0] errNow;

  always_comb begin
    awFire = evt.fire[CH_AW];
    wFire  = evt.fire[CH_W];
    bFire  = evt.fire[CH_B];
    arFire = evt.fire[CH_AR];
    rFire  = evt.fire[CH_R];
    awLen1 = CW'(awLen) + CW'(1);
    arLen1 = CW'(arLen) + CW'(1);
  end

  // Write direction: address, data (possibly early) and response
  always_comb begin
    wAddrNx  = wAddrSeen;
    wDoneNx  = wDataDone;
    wCntNx   = wCnt;
    wLenNx   = wLen1;
    wLastErr = 1'b0;
    wOvfErr  = 1'b0;
    bOrdErr  = 1'b0;
    addrNow  = wAddrSeen | awFire;
    lenNow   = wAddrSeen ? wLen1 : awLen1;
    wNew     = wCnt + CW'(1);

    if (wFire) begin
      if (wDataDone) begin
        wOvfErr = 1'b1;
      end else begin
        wCntNx = wNew;
        if (addrNow) begin
          wLastErr = (wNew > lenNow) | (evt.wLast != (wNew == lenNow));
          wDoneNx  = evt.wLast | (wNew >= lenNow);
        end else begin
          wDoneNx = evt.wLast;
        end
      end
    end else if (awFire && !wAddrSeen) begin
      // reconcile beats that arrived ahead of the address
      if (wDataDone) begin
        wLastErr = (wCnt != awLen1);
      end else if (wCnt >= awLen1) begin
        wLastErr = 1'b1;
        wDoneNx  = 1'b1;
      end
    end

    if (awFire) begin
      if (!wAddrSeen) begin
        wAddrNx = 1'b1;
        wLenNx  = awLen1;
      end else if (!bFire) begin
        wOvfErr = 1'b1;
      end
    end

    if (evt.bValid && !(wAddrSeen && wDataDone)) bOrdErr = 1'b1;

    if (bFire) begin
      wAddrNx = 1'b0;
      wDoneNx = 1'b0;
      wCntNx  = '0;
      if (awFire && wAddrSeen) begin
        wAddrNx = 1'b1;
        wLenNx  = awLen1;
      end
    end
  end

  // Read direction: address then data
  always_comb begin
    rAddrNx  = rAddrSeen;
    rCntNx   = rCnt;
    rLenNx   = rLen1;
    rLastErr = 1'b0;
    rOrdErr  = 1'b0;
    rOvfErr  = 1'b0;
    rDoneNow = 1'b0;
    rNew     = rCnt + CW'(1);

    if (rFire) begin
      if (!rAddrSeen) begin
        rOrdErr = 1'b1;
      end else begin
        rCntNx   = rNew;
        rLastErr = evt.rLast != (rNew == rLen1);
        rDoneNow = evt.rLast | (rNew >= rLen1);
      end
    end

    if (rDoneNow) begin
      rAddrNx = 1'b0;
      rCntNx  = '0;
    end

    if (arFire) begin
      if (!rAddrSeen || rDoneNow) begin
        rAddrNx = 1'b1;
        rLenNx  = arLen1;
        rCntNx  = '0;
      end else begin
        rOvfErr = 1'b1;
      end
    end
  end

  always_comb begin
    errNow = '0;
    errNow[DROP_BASE +: NUM_CH] = evt.drop;
    errNow[HOLD_BASE +: NUM_CH] = evt.hold;
    errNow[ERR_WLAST] = wLastErr;
    errNow[ERR_RLAST] = rLastErr;
    errNow[ERR_BORD]  = bOrdErr;
    errNow[ERR_RORD]  = rOrdErr;
    errNow[ERR_WOVF]  = wOvfErr;
    errNow[ERR_ROVF]  = rOvfErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wAddrSeen <= 1'b0;
      wDataDone <= 1'b0;
      wCnt      <= '0;
      wLen1     <= '0;
      rAddrSeen <= 1'b0;
      rCnt      <= '0;
      rLen1     <= '0;
      errFlags  <= '0;
    end else begin
      wAddrSeen <= wAddrNx;
      wDataDone <= wDoneNx;
      wCnt      <= wCntNx;
      wLen1     <= wLenNx;
      rAddrSeen <= rAddrNx;
      rCnt      <= rCntNx;
      rLen1     <= rLenNx;
      errFlags  <= errFlags | errNow;
    end
  end
endmodule

// File: rtl/hsLinkMonitor.sv
module hsLinkMonitor
  import hsmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int RESP_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                awValid,
  input  logic                awReady,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic [LEN_W-1:0]    awLen,
  input  logic                wValid,
  input  logic                wReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wLast,
  input  logic                bValid,
  input  logic                bReady,
  input  logic [RESP_W-1:0]   bResp,
  input  logic                arValid,
  input  logic                arReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic [LEN_W-1:0]    arLen,
  input  logic                rValid,
  input  logic                rReady,
  input  logic [DATA_W-1:0]   rData,
  input  logic [RESP_W-1:0]   rResp,
  input  logic                rLast,
  output logic [15:0]         errFlags,
  output logic                errAny
);
  evt_t evt;
  logic [NUM_ERR-1:0] flagsQ;

  hsMonDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RESP_W(RESP_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp), .rLast(rLast),
    .evt(evt)
  );

  hsMonControl #(.LEN_W(LEN_W)) uCtl (
    .clk(clk), .rstN(rstN), .evt(evt),
    .awLen(awLen), .arLen(arLen),
    .errFlags(flagsQ)
  );

  assign errFlags = flagsQ;
  assign errAny   = |flagsQ;
endmodule

// File: rtl/hsLinkMonitor_chk.sv
module hsLinkMonitor_chk (
  input logic        clk,
  input logic        rstN,
  input logic        awValid,
  input logic        awReady,
  input logic [31:0] awAddr,
  input logic        wValid,
  input logic        wReady,
  input logic        rValid,
  input logic        rReady,
  input logic [15:0] errFlags,
  input logic        errAny
);
  // R1
  aw_drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) ##1 !awValid |=> errFlags[0]);

  // R1
  w_drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) ##1 !wValid |=> errFlags[1]);

  // R1
  r_drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) ##1 !rValid |=> errFlags[4]);

  // R2
  aw_hold_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) ##1 (awValid && (awAddr != $past(awAddr))) |=> errFlags[5]);

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(errFlags) & ~errFlags) == 16'h0));

  // R9
  any_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> errAny);
endmodule

bind hsLinkMonitor hsLinkMonitor_chk uChk (
  .clk(clk), .rstN(rstN),
  .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
  .wValid(wValid), .wReady(wReady),
  .rValid(rValid), .rReady(rReady),
  .errFlags(errFlags), .errAny(errAny)
);

// File: tb/tb_hsLinkMonitor.sv
module tb_hsLinkMonitor;
  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] F_AWDROP = 16'h0001;
  localparam logic [15:0] F_RDROP  = 16'h0010;
  localparam logic [15:0] F_WHOLD  = 16'h0040;
  localparam logic [15:0] F_ARHOLD = 16'h0100;
  localparam logic [15:0] F_WLAST  = 16'h0400;
  localparam logic [15:0] F_RLAST  = 16'h0800;
  localparam logic [15:0] F_BORD   = 16'h1000;
  localparam logic [15:0] F_RORD   = 16'h2000;
  localparam logic [15:0] F_WOVF   = 16'h4000;
  localparam logic [15:0] F_ROVF   = 16'h8000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        awValid, awReady, wValid, wReady, wLast, bValid, bReady;
  logic        arValid, arReady, rValid, rReady, rLast;
  logic [31:0] awAddr, arAddr, wData, rData;
  logic [7:0]  awLen, arLen;
  logic [3:0]  wStrb;
  logic [1:0]  bResp, rResp;
  logic [15:0] errFlags;
  logic        errAny;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsLinkMonitor dut (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp), .rLast(rLast),
    .errFlags(errFlags), .errAny(errAny)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idleAll();
    awValid = 0; awReady = 0; awAddr = 0; awLen = 0;
    wValid = 0; wReady = 0; wData = 0; wStrb = 0; wLast = 0;
    bValid = 0; bReady = 0; bResp = 0;
    arValid = 0; arReady = 0; arAddr = 0; arLen = 0;
    rValid = 0; rReady = 0; rData = 0; rResp = 0; rLast = 0;
  endtask

  task automatic doReset();
    idleAll();
    rstN = 0;
    step(2);
    rstN = 1;
    step(1);
  endtask

  task automatic check(string tag, logic [15:0] exp);
    nChk++;
    if (errFlags !== exp || errAny !== (|exp)) begin
      nBad++;
      $display("FAIL %s: flags=%h any=%b expected flags=%h any=%b",
               tag, errFlags, errAny, exp, |exp);
    end
  endtask

  task automatic awBeat(logic [7:0] len);
    awValid = 1; awReady = 1; awLen = len; awAddr = 32'h100 + 32'(len);
    step();
    awValid = 0; awReady = 0;
  endtask

  task automatic arBeat(logic [7:0] len);
    arValid = 1; arReady = 1; arLen = len; arAddr = 32'h200 + 32'(len);
    step();
    arValid = 0; arReady = 0;
  endtask

  task automatic wBeat(logic last, logic [31:0] d);
    wValid = 1; wReady = 1; wLast = last; wData = d; wStrb = d[3:0];
    step();
    wValid = 0; wReady = 0; wLast = 0;
    wStrb = ~d[3:0];
  endtask

  task automatic rBeat(logic last, logic [31:0] d);
    rValid = 1; rReady = 1; rLast = last; rData = d;
    step();
    rValid = 0; rReady = 0; rLast = 0;
  endtask

  task automatic bBeat();
    bValid = 1; bReady = 1; bResp = 2'b00;
    step();
    bValid = 0; bReady = 0;
  endtask

  task automatic tReset();
    idleAll();
    rstN = 0;
    step(1);
    check("R10 flags low during reset", 16'h0);
    rstN = 1;
    step(2);
    check("R10 flags low after reset", 16'h0);
  endtask

  task automatic tCleanWrite();
    doReset();
    awValid = 1; awReady = 0; awLen = 8'd2; awAddr = 32'h40;
    step();
    awReady = 1;
    step();
    awValid = 0; awReady = 0;
    wStrb = 4'hA; step(); wStrb = 4'h5; step();
    wBeat(0, 32'h11);
    wValid = 1; wReady = 0; wData = 32'h22; wStrb = 4'h3;
    step();
    wReady = 1;
    step();
    wValid = 0; wReady = 0; wStrb = 4'hF;
    wBeat(1, 32'h33);
    bValid = 1; bReady = 0; bResp = 2'b01;
    step();
    bReady = 1;
    step();
    bValid = 0; bReady = 0;
    step(2);
    check("R6 R3 legal stalled write burst", 16'h0);
  endtask

  task automatic tEarlyWrite();
    doReset();
    wBeat(0, 32'hA1);
    wBeat(1, 32'hA2);
    awBeat(8'd1);
    bBeat();
    step(2);
    check("R7 write data fully before address", 16'h0);
    wBeat(0, 32'hB1);
    awBeat(8'd1);
    wBeat(1, 32'hB2);
    bBeat();
    step(2);
    check("R7 write data straddling address", 16'h0);
  endtask

  task automatic tEarlyWrong();
    doReset();
    wBeat(0, 1); wBeat(0, 2); wBeat(1, 3);
    awBeat(8'd1);
    step(2);
    check("R7 early burst size mismatch", F_WLAST);
  endtask

  task automatic tCleanRead();
    doReset();
    arBeat(8'd1);
    rValid = 1; rReady = 0; rData = 32'h55; rLast = 0;
    step();
    rReady = 1;
    step();
    rValid = 0; rReady = 0;
    rBeat(1, 32'h66);
    step(2);
    check("R4 R6 legal read burst", 16'h0);
  endtask

  task automatic tDrop();
    doReset();
    awValid = 1; awReady = 0; awAddr = 32'h80;
    step();
    awValid = 0;
    step(2);
    check("R1 write address VALID dropped", F_AWDROP);
    step(5);
    check("R9 drop flag sticky", F_AWDROP);
    doReset();
    check("R10 reset clears sticky flag", 16'h0);
    rValid = 1; rReady = 0; rData = 32'h9;
    step();
    rValid = 0;
    step(2);
    check("R1 read data VALID dropped", F_RDROP);
  endtask

  task automatic tHold();
    doReset();
    wValid = 1; wReady = 0; wData = 32'hAAAA; wStrb = 4'hF; wLast = 1;
    step();
    wData = 32'hBBBB; wReady = 1;
    step();
    wValid = 0; wReady = 0; wLast = 0;
    step(2);
    check("R2 write data changed while stalled", F_WHOLD);
    doReset();
    arValid = 1; arReady = 0; arAddr = 32'h10; arLen = 0;
    step();
    arAddr = 32'h20; arReady = 1;
    step();
    arValid = 0; arReady = 0;
    step(2);
    check("R2 read address changed while stalled", F_ARHOLD);
  endtask

  task automatic tOrder();
    doReset();
    awBeat(8'd0);
    bBeat();
    step(2);
    check("R5 response before final write beat", F_BORD);
    doReset();
    rBeat(1, 32'h7);
    step(2);
    check("R4 read data with no open request", F_RORD);
  endtask

  task automatic tLast();
    doReset();
    awBeat(8'd2);
    wBeat(0, 1); wBeat(1, 2);
    bBeat();
    step(2);
    check("R6 write last flag early", F_WLAST);
    doReset();
    arBeat(8'd1);
    rBeat(0, 1); rBeat(0, 2);
    step(2);
    check("R6 read last flag missing", F_RLAST);
  endtask

  task automatic tOverflow();
    doReset();
    awBeat(8'd0);
    wBeat(1, 1);
    wBeat(1, 2);
    bBeat();
    step(2);
    check("R8 extra write beat before response", F_WOVF);
    doReset();
    arBeat(8'd0);
    arBeat(8'd0);
    step(2);
    check("R8 second read request while open", F_ROVF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    idleAll();
    step(1);
    tReset();
    tCleanWrite();
    tEarlyWrite();
    tEarlyWrong();
    tCleanRead();
    tDrop();
    tHold();
    tOrder();
    tLast();
    tOverflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule